// File: doc/BRIEF.md
# Memory Dependence Hazard Window

This block keeps a short window of memory operations in program order and works out, every time the window changes, which of them could run now without breaking an ordering rule. Each slot holds a kind (load or store), a base register value, a signed offset and a flag that says whether the base value is known yet. The effective address of a slot is its base plus its sign-extended offset. For every pair of slots, where the lower index is the older one, the block tests for a possible alias. It then sets a true-dependence flag, an anti-dependence flag or an output-dependence flag, depending on the two kinds.

A front end pushes operations at the young end and retires them from the old end. A base value that arrives late can be filled in through a separate update port. The per-slot issue permission and the three hazard vectors come from registers that follow the window one cycle behind. A scheduler reads them without any combinational path back to its own requests. Only whole-word address equality is tested; every unresolved address is assumed to alias.

Top module: `memdep_classifier`

## Requirements
- R1: A slot's effective address is `base + sign_extend(offset)` taken modulo 2^AW, so different base/offset pairs with the same sum alias, including sums that wrap past zero.
- R2: `enq_valid` writes into the lowest free slot. `retire` drops slot 0 and moves every other slot down by one index. When both come in one cycle, the retire is applied first. An enqueue into a full window without retire is ignored, and so is a retire on an empty window. `occupancy` shows the new count right after the clock edge.
- R3: Bit j of `raw_hit` is 1 when a valid younger load j has a valid older store that may alias it.
- R4: Bit j of `war_hit` is 1 when a valid younger store j has a valid older load that may alias it.
- R5: Bit j of `waw_hit` is 1 when a valid younger store j has a valid older store that may alias it.
- R6: Two loads never raise any hazard flag against each other, whatever their addresses.
- R7: Two slots may alias when either of their addresses is unknown (`enq_base_ok` was 0 and no update has landed yet) or when their effective addresses are equal. `upd_valid` writes `upd_base` into valid slot `upd_idx` and marks its address known. This happens before any shift in the same cycle, and the update is ignored for an empty slot.
- R8: Bit j of `may_issue` is 1 only when slot j is valid, its address is known, and it has no hazard against any older slot. The oldest slot is therefore free as soon as its address is known.
- R9: An older store and a younger load at the same known address are never both issuable in the same cycle.
- R10: `may_issue`, `raw_hit`, `war_hit` and `waw_hit` reflect the window as it stood after the previous clock edge, so they lag one cycle behind any enqueue, retire or update.
- R11: After reset the window is empty, `occupancy` is 0 and every hazard and issue bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Push one operation at the young end |
| enq_store | input | 1 | Kind of the pushed operation: 1 store, 0 load |
| enq_base | input | AW | Base register value of the pushed operation |
| enq_off | input | OW | Signed offset of the pushed operation |
| enq_base_ok | input | 1 | Base value of the pushed operation is already known |
| upd_valid | input | 1 | Fill in a late base value |
| upd_idx | input | IW | Slot index the late base value belongs to |
| upd_base | input | AW | Late base value |
| retire | input | 1 | Remove the oldest slot |
| occupancy | output | CW | Number of valid slots |
| may_issue | output | DEPTH | Per-slot issue permission, bit 0 oldest |
| raw_hit | output | DEPTH | Per-slot true-dependence flag |
| war_hit | output | DEPTH | Per-slot anti-dependence flag |
| waw_hit | output | DEPTH | Per-slot output-dependence flag |

## Verification
The assertions rely on two facts about the inputs:
- A slot's kind is written only on enqueue and then moves with the slot, so a past kind sampled at an index matches the flag computed for that index.
- The valid slots always form an unbroken run from index 0, because enqueue fills the lowest free slot.

The stimulus keeps to the port contract but probes its edges. It enqueues into a full window, retires from an empty one, aims updates at empty slots, and issues retire together with enqueue and update. Addresses are drawn from a small pool of bases and offsets so that aliases, including aliases between different base/offset pairs, happen often.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
  typedef enum logic {OP_LOAD = 1'b0, OP_STORE = 1'b1} mem_op_e;
endpackage

// File: rtl/memdep_window.sv
module memdep_window import memdep_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int OW = 12,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_valid,
  input  logic                       enq_store,
  input  logic [AW-1:0]              enq_base,
  input  logic [OW-1:0]              enq_off,
  input  logic                       enq_base_ok,
  input  logic                       upd_valid,
  input  logic [IW-1:0]              upd_idx,
  input  logic [AW-1:0]              upd_base,
  input  logic                       retire,
  output logic [DEPTH-1:0]           v_o,
  output logic [DEPTH-1:0]           st_o,
  output logic [DEPTH-1:0]           av_o,
  output logic [DEPTH-1:0][AW-1:0]   base_o,
  output logic [DEPTH-1:0][OW-1:0]   off_o,
  output logic [CW-1:0]              cnt_o,
  output logic                       chg_o
);
  logic [DEPTH-1:0]         v_q, v_n, st_q, st_n, av_q, av_n;
  logic [DEPTH-1:0][AW-1:0] base_q, base_n;
  logic [DEPTH-1:0][OW-1:0] off_q, off_n;
  logic [CW-1:0]            cnt_q, cnt_n;
  logic                     win_en, do_ret, enq_ok;

  assign win_en = enq_valid | upd_valid | retire;
  assign do_ret = retire && (cnt_q != '0);

  // Order inside a cycle: late base fill, then retire shift, then enqueue.
  always_comb begin
    v_n    = v_q;
    st_n   = st_q;
    av_n   = av_q;
    base_n = base_q;
    off_n  = off_q;
    cnt_n  = cnt_q;
    if (upd_valid && v_q[upd_idx]) begin
      base_n[upd_idx] = upd_base;
      av_n[upd_idx]   = 1'b1;
    end
    if (do_ret) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        v_n[k]    = v_n[k+1];
        st_n[k]   = st_n[k+1];
        av_n[k]   = av_n[k+1];
        base_n[k] = base_n[k+1];
        off_n[k]  = off_n[k+1];
      end
      v_n[DEPTH-1]    = 1'b0;
      st_n[DEPTH-1]   = 1'b0;
      av_n[DEPTH-1]   = 1'b0;
      base_n[DEPTH-1] = '0;
      off_n[DEPTH-1]  = '0;
      cnt_n           = cnt_n - 1'b1;
    end
    enq_ok = enq_valid && (cnt_n < CW'(DEPTH));
    if (enq_ok) begin
      v_n[cnt_n[IW-1:0]]    = 1'b1;
      st_n[cnt_n[IW-1:0]]   = (mem_op_e'(enq_store) == OP_STORE);
      av_n[cnt_n[IW-1:0]]   = enq_base_ok;
      base_n[cnt_n[IW-1:0]] = enq_base;
      off_n[cnt_n[IW-1:0]]  = enq_off;
      cnt_n                 = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      st_q   <= '0;
      av_q   <= '0;
      base_q <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
    end else if (win_en) begin
      v_q    <= v_n;
      st_q   <= st_n;
      av_q   <= av_n;
      base_q <= base_n;
      off_q  <= off_n;
      cnt_q  <= cnt_n;
    end
  end

  assign v_o    = v_q;
  assign st_o   = st_q;
  assign av_o   = av_q;
  assign base_o = base_q;
  assign off_o  = off_q;
  assign cnt_o  = cnt_q;
  assign chg_o  = win_en;

  // R2: occupancy bounded and equal to the number of valid slots
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(DEPTH)) && (cnt_q == CW'($countones(v_q))));

  // R2: a retire on a non-empty window without enqueue shrinks it by one
  p_retire_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && (cnt_q != '0) && !enq_valid) |=> (cnt_q == $past(cnt_q) - 1'b1));

  genvar g;
  for (g = 0; g < DEPTH - 1; g++) begin : g_prefix
    // R2: valid slots form an unbroken run from the oldest index
    p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[g+1] |-> v_q[g]);
  end
endmodule

// File: rtl/memdep_ea.sv
module memdep_ea #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] ea_o
);
  logic [AW-1:0] off_x;
  assign off_x = {{(AW-OW){off_i[OW-1]}}, off_i};
  assign ea_o  = base_i + off_x;
endmodule

// File: rtl/memdep_pairs.sv
module memdep_pairs #(
  parameter int DEPTH = 4,
  parameter int AW = 32
) (
  input  logic [DEPTH-1:0]         v_i,
  input  logic [DEPTH-1:0]         st_i,
  input  logic [DEPTH-1:0]         av_i,
  input  logic [DEPTH-1:0][AW-1:0] ea_i,
  output logic [DEPTH-1:0]         raw_c,
  output logic [DEPTH-1:0]         war_c,
  output logic [DEPTH-1:0]         waw_c,
  output logic [DEPTH-1:0]         may_c
);
  genvar j, i;
  for (j = 0; j < DEPTH; j++) begin : g_young
    logic [DEPTH-1:0] r_m, a_m, o_m;
    for (i = 0; i < DEPTH; i++) begin : g_old
      if (i < j) begin : g_pair
        logic maybe_same;
        assign maybe_same = v_i[i] && v_i[j] &&
                            (!av_i[i] || !av_i[j] || (ea_i[i] == ea_i[j]));
        assign r_m[i] = maybe_same &&  st_i[i] && !st_i[j];
        assign a_m[i] = maybe_same && !st_i[i] &&  st_i[j];
        assign o_m[i] = maybe_same &&  st_i[i] &&  st_i[j];
      end else begin : g_none
        assign r_m[i] = 1'b0;
        assign a_m[i] = 1'b0;
        assign o_m[i] = 1'b0;
      end
    end
    assign raw_c[j] = |r_m;
    assign war_c[j] = |a_m;
    assign waw_c[j] = |o_m;
    assign may_c[j] = v_i[j] && av_i[j] && !(|r_m) && !(|a_m) && !(|o_m);
  end
endmodule

// File: rtl/memdep_classifier.sv
module memdep_classifier #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int OW = 12,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic             enq_store,
  input  logic [AW-1:0]    enq_base,
  input  logic [OW-1:0]    enq_off,
  input  logic             enq_base_ok,
  input  logic             upd_valid,
  input  logic [IW-1:0]    upd_idx,
  input  logic [AW-1:0]    upd_base,
  input  logic             retire,
  output logic [CW-1:0]    occupancy,
  output logic [DEPTH-1:0] may_issue,
  output logic [DEPTH-1:0] raw_hit,
  output logic [DEPTH-1:0] war_hit,
  output logic [DEPTH-1:0] waw_hit
);
  logic [DEPTH-1:0]         w_v, w_st, w_av;
  logic [DEPTH-1:0][AW-1:0] w_base, ea_w;
  logic [DEPTH-1:0][OW-1:0] w_off;
  logic                     w_chg, chg_q, hz_en;
  logic [DEPTH-1:0]         raw_c, war_c, waw_c, may_c;
  logic [DEPTH-1:0]         raw_q, war_q, waw_q, may_q;

  memdep_window #(.DEPTH(DEPTH), .AW(AW), .OW(OW)) u_win (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_store(enq_store), .enq_base(enq_base),
    .enq_off(enq_off), .enq_base_ok(enq_base_ok),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_base(upd_base),
    .retire(retire),
    .v_o(w_v), .st_o(w_st), .av_o(w_av), .base_o(w_base), .off_o(w_off),
    .cnt_o(occupancy), .chg_o(w_chg)
  );

  genvar e;
  for (e = 0; e < DEPTH; e++) begin : g_ea
    memdep_ea #(.AW(AW), .OW(OW)) u_ea (
      .base_i(w_base[e]), .off_i(w_off[e]), .ea_o(ea_w[e])
    );
  end

  memdep_pairs #(.DEPTH(DEPTH), .AW(AW)) u_pairs (
    .v_i(w_v), .st_i(w_st), .av_i(w_av), .ea_i(ea_w),
    .raw_c(raw_c), .war_c(war_c), .waw_c(waw_c), .may_c(may_c)
  );

  // Flags reload only in the cycle after the window moved.
  assign hz_en = chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= 1'b0;
      raw_q <= '0;
      war_q <= '0;
      waw_q <= '0;
      may_q <= '0;
    end else begin
      chg_q <= w_chg;
      if (hz_en) begin
        raw_q <= raw_c;
        war_q <= war_c;
        waw_q <= waw_c;
        may_q <= may_c;
      end
    end
  end

  assign raw_hit   = raw_q;
  assign war_hit   = war_q;
  assign waw_hit   = waw_q;
  assign may_issue = may_q;

  // R8: the oldest slot with a known address is never held back
  p_oldest_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_v[0] && w_av[0]) |-> may_issue[0]);

  genvar a, b;
  for (b = 0; b < DEPTH; b++) begin : g_kind
    // R6: anti/output flags only on stores, true flags only on loads
    p_kind_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (war_hit[b] || waw_hit[b]) |-> $past(w_st[b]));
    p_kind_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      raw_hit[b] |-> !$past(w_st[b]));
    for (a = 0; a < b; a++) begin : g_raw
      // R9: older store and younger load at one known address never both issue
      p_raw_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (may_issue[a] && may_issue[b]) |->
          !$past(w_st[a] && !w_st[b] && w_av[a] && w_av[b] && (ea_w[a] == ea_w[b])));
    end
  end
endmodule

// File: tb/tb_memdep_classifier.sv
`timescale 1ns/1ps
module tb_memdep_classifier;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int OW = 12;

  logic          clk, rst_n;
  logic          enq_valid, enq_store, enq_base_ok, upd_valid, retire;
  logic [AW-1:0] enq_base, upd_base;
  logic [OW-1:0] enq_off;
  logic [1:0]    upd_idx;
  logic [2:0]    occupancy;
  logic [3:0]    may_issue, raw_hit, war_hit, waw_hit;

  memdep_classifier dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_store(enq_store),
    .enq_base(enq_base), .enq_off(enq_off), .enq_base_ok(enq_base_ok),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_base(upd_base),
    .retire(retire), .occupancy(occupancy), .may_issue(may_issue),
    .raw_hit(raw_hit), .war_hit(war_hit), .waw_hit(waw_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: behavioural window held as plain arrays
  bit            m_v[DEPTH], m_st[DEPTH], m_av[DEPTH];
  logic [AW-1:0] m_base[DEPTH];
  logic [OW-1:0] m_off[DEPTH];
  int            m_cnt;
  logic [3:0]    e_may, e_raw, e_war, e_waw;

  function automatic logic [AW-1:0] addr_of(input logic [AW-1:0] b, input logic [OW-1:0] o);
    return b + {{(AW-OW){o[OW-1]}}, o};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        m_v[k] = 0; m_st[k] = 0; m_av[k] = 0; m_base[k] = '0; m_off[k] = '0;
      end
      m_cnt = 0; e_may = 0; e_raw = 0; e_war = 0; e_waw = 0;
    end else begin
      e_may = 0; e_raw = 0; e_war = 0; e_waw = 0;
      for (int y = 0; y < DEPTH; y++) begin
        bit blocked;
        blocked = 0;
        for (int o = 0; o < y; o++) begin
          if (m_v[o] && m_v[y] && (!m_av[o] || !m_av[y] ||
              addr_of(m_base[o], m_off[o]) == addr_of(m_base[y], m_off[y]))) begin
            if (m_st[o] && !m_st[y]) begin e_raw[y] = 1; blocked = 1; end
            if (!m_st[o] && m_st[y]) begin e_war[y] = 1; blocked = 1; end
            if (m_st[o] && m_st[y]) begin e_waw[y] = 1; blocked = 1; end
          end
        end
        e_may[y] = m_v[y] && m_av[y] && !blocked;
      end
      if (upd_valid && m_v[upd_idx]) begin
        m_base[upd_idx] = upd_base; m_av[upd_idx] = 1;
      end
      if (retire && m_cnt > 0) begin
        for (int k = 0; k < DEPTH - 1; k++) begin
          m_v[k] = m_v[k+1]; m_st[k] = m_st[k+1]; m_av[k] = m_av[k+1];
          m_base[k] = m_base[k+1]; m_off[k] = m_off[k+1];
        end
        m_v[DEPTH-1] = 0; m_st[DEPTH-1] = 0; m_av[DEPTH-1] = 0;
        m_cnt--;
      end
      if (enq_valid && m_cnt < DEPTH) begin
        m_v[m_cnt] = 1; m_st[m_cnt] = enq_store; m_av[m_cnt] = enq_base_ok;
        m_base[m_cnt] = enq_base; m_off[m_cnt] = enq_off;
        m_cnt++;
      end
    end
  end

  task automatic compare_model();
    chk(occupancy == 3'(m_cnt), "R2 occupancy", 32'(occupancy), 32'(m_cnt));
    chk(raw_hit == e_raw, "R3 raw_hit", 32'(raw_hit), 32'(e_raw));
    chk(war_hit == e_war, "R4 war_hit", 32'(war_hit), 32'(e_war));
    chk(waw_hit == e_waw, "R5 waw_hit", 32'(waw_hit), 32'(e_waw));
    chk(may_issue == e_may, "R8 may_issue", 32'(may_issue), 32'(e_may));
  endtask

  task automatic step(input bit en, input bit st, input logic [AW-1:0] b, input logic [OW-1:0] o,
                      input bit ok, input bit up, input logic [1:0] ui, input logic [AW-1:0] ub,
                      input bit rt);
    enq_valid = en; enq_store = st; enq_base = b; enq_off = o; enq_base_ok = ok;
    upd_valid = up; upd_idx = ui; upd_base = ub; retire = rt;
    @(posedge clk);
    @(negedge clk);
    enq_valid = 0; upd_valid = 0; retire = 0;
    compare_model();
  endtask

  task automatic idle();
    step(0, 0, '0, '0, 0, 0, 2'd0, '0, 0);
  endtask

  initial begin
    rst_n = 0; enq_valid = 0; enq_store = 0; enq_base = '0; enq_off = '0;
    enq_base_ok = 0; upd_valid = 0; upd_idx = '0; upd_base = '0; retire = 0;
    repeat (3) @(negedge clk);
    chk(occupancy == 0, "R11 occupancy", 32'(occupancy), 0);
    chk(may_issue == 0, "R11 may_issue", 32'(may_issue), 0);
    chk((raw_hit | war_hit | waw_hit) == 0, "R11 flags", 32'(raw_hit | war_hit | waw_hit), 0);
    rst_n = 1;
    @(negedge clk);

    step(1, 1, 32'h100, 12'h000, 1, 0, 0, 0, 0);           // store @0x100
    chk(occupancy == 1, "R10 occupancy immediate", 32'(occupancy), 1);
    chk(may_issue == 0, "R10 flags lag", 32'(may_issue), 0);
    step(1, 0, 32'h108, 12'hFF8, 1, 0, 0, 0, 0);           // load 0x108-8
    chk(may_issue == 4'b0001, "R10 one-slot view", 32'(may_issue), 1);
    idle();
    chk(raw_hit == 4'b0010, "R1 R3 alias via offset", 32'(raw_hit), 2);
    chk(may_issue == 4'b0001, "R9 load held behind store", 32'(may_issue), 1);
    step(1, 0, 32'h0FC, 12'h004, 1, 0, 0, 0, 0);           // load 0xFC+4
    idle();
    chk(raw_hit == 4'b0110, "R3 two loads behind store", 32'(raw_hit), 6);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);                       // retire store
    idle();
    chk((raw_hit | war_hit | waw_hit) == 0, "R6 load pair", 32'(raw_hit | war_hit | waw_hit), 0);
    chk(may_issue == 4'b0011, "R6 loads both free", 32'(may_issue), 3);
    step(1, 1, 32'h100, 12'h000, 1, 0, 0, 0, 0);           // store @0x100
    step(1, 1, 32'h200, 12'h000, 0, 0, 0, 0, 0);           // store, unknown base
    idle();
    chk(war_hit == 4'b1100, "R4 R7 anti", 32'(war_hit), 12);
    chk(waw_hit == 4'b1000, "R5 R7 output", 32'(waw_hit), 8);
    chk(may_issue == 4'b0011, "R7 unknown blocked", 32'(may_issue), 3);
    step(1, 0, 32'h500, 12'h000, 1, 0, 0, 0, 0);           // full: ignored
    chk(occupancy == 4, "R2 full ignores enqueue", 32'(occupancy), 4);
    step(0, 0, 0, 0, 0, 1, 2'd3, 32'h300, 0);              // base now known
    idle();
    chk(war_hit == 4'b0100, "R7 update clears alias", 32'(war_hit), 4);
    chk(may_issue == 4'b1011, "R8 resolved store free", 32'(may_issue), 11);
    step(1, 0, 32'h300, 12'h000, 1, 0, 0, 0, 1);           // retire + load
    chk(occupancy == 4, "R2 retire with enqueue", 32'(occupancy), 4);
    idle();
    chk(raw_hit == 4'b1000, "R3 after shift", 32'(raw_hit), 8);
    chk(war_hit == 4'b0010, "R4 after shift", 32'(war_hit), 2);
    chk(may_issue == 4'b0101, "R8 after shift", 32'(may_issue), 5);
    repeat (5) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(occupancy == 0, "R2 empty ignores retire", 32'(occupancy), 0);
    step(1, 1, 32'h0000_0004, 12'h000, 1, 0, 0, 0, 0);
    step(1, 0, 32'hFFFF_FFFC, 12'h008, 1, 0, 0, 0, 0);
    idle();
    chk(raw_hit == 4'b0010, "R1 wrapped sum aliases", 32'(raw_hit), 2);

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] bs;
      logic [OW-1:0] of;
      bs = 32'h100 + 32'($urandom_range(0, 2) * 4);
      of = 12'($signed($urandom_range(0, 2) * 4) - 4);
      step($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, bs, of,
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)),
           32'h100 + 32'($urandom_range(0, 2) * 4), $urandom_range(0, 2) == 0);
    end
    repeat (3) idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule